// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

The aggregator collects up to 32 interrupt request lines and merges them into one request towards a parent controller. Software programs each line as level or edge sensitive, with its own polarity. Every line has a pending bit. A pending bit is raised by the selected condition on the line, or by a software force. Software clears a pending bit by writing a one to it. A per-line enable decides whether a pending bit reaches the merged request. Masking never clears the pending bit.

The merged request drives one output pin. That pin has its own programmable shape: a level, or a one-clock pulse each time the request becomes new. It also has its own polarity. Software reaches all settings through a small synchronous bus with a word index, a write strobe and combinational read data.

Each line passes through a two-flop synchroniser and then a source cell. The output pin is shaped by a four-state machine:
- `OUT_IDLE`: inactive.
- `OUT_LEVEL`: active, level shape.
- `OUT_PULSE`: active for a single clock, pulse shape.
- `OUT_HOLD`: inactive, waiting for the request to fall.

The transitions are as follows:
- Idle to level when a request arrives in level shape.
- Idle to pulse when a request arrives in pulse shape.
- Pulse to hold while the request remains.
- Level or hold back to idle when the request drops.
- A shape change moves level to hold, or hold to level.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is 1, the inactive value of an active-low level output. The bench keeps idle inputs at 1.
- R2: Word index 0 is enable, 1 is pending status, 2 is source mode and 3 is source polarity. Index 4 is output mode and 5 is output polarity; each uses bit 0 only, and bits 31:1 read 0. Index 6 is force. Force and index 7 always read 0. Enable, mode and polarity read back what was written.
- R3: Source mode bit 1 selects edge detection: polarity 1 means a rising edge and polarity 0 means a falling edge. The pending bit is visible after the third rising clock edge following the input change. It stays set after the input returns.
- R4: Source mode bit 0 selects level detection: polarity 1 means active high and polarity 0 means active low. The pending bit is set while the line is active. A write-one-to-clear while the line is active leaves it at 1. The bit remains set after the line goes inactive, until it is cleared.
- R5: Writing 1 to a status bit clears that pending bit. Writing 0 leaves it unchanged.
- R6: Writing 1 to a force bit sets that pending bit at the write's clock edge.
- R7: An enable bit of 0 keeps its pending bit away from the output and leaves the pending bit intact. Setting the enable later activates the output.
- R8: With output mode 0, `irq_out` equals the output polarity bit from one clock after any enabled pending bit is set. It stays there until no enabled pending bit remains.
- R9: With output mode 1, each rise of the merged request gives a one-clock pulse at the output polarity. No further pulse occurs until the request has fallen to 0.
- R10: After a mode or polarity change leaves a stale pending bit, a write-one-to-clear removes it for good while the line stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Asynchronous interrupt request lines |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Merged interrupt output |

## Verification
The hardest situation to reach is a pending bit that software can no longer explain. Such a bit is left behind when a line is reprogrammed from level to edge detection while its input stays steady. The stimulus first latches the bit under active-low level detection, then releases the line. It then rewrites mode and polarity to rising edge without any transition. Finally it confirms that the stale bit survives until one write-one-to-clear, and stays clear afterwards. Pulse-shape suppression is reached by forcing a second enabled line while the request is already high.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RS_ENABLE  = 3'd0,
        RS_STATUS  = 3'd1,
        RS_SMODE   = 3'd2,
        RS_SPOL    = 3'd3,
        RS_OMODE   = 3'd4,
        RS_OPOL    = 3'd5,
        RS_FORCE   = 3'd6,
        RS_SPARE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_LEVEL = 2'd1,
        OUT_PULSE = 2'd2,
        OUT_HOLD  = 2'd3
    } out_state_e;

endpackage

// File: rtl/irq_gather_sync.sv
module irq_gather_sync #(
    parameter int   WIDTH     = 32,
    parameter logic RESET_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= {WIDTH{RESET_BIT}};
            stage2_q <= {WIDTH{RESET_BIT}};
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/irq_gather_cell.sv
module irq_gather_cell #(
    parameter logic IDLE_BIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic edge_mode,
    input  logic hi_pol,
    input  logic ack,
    input  logic force_set,
    output logic pending
);
    logic prev_q;
    logic pend_q;
    logic hit;

    // Edge mode compares against last sample; level mode tracks activity.
    always_comb begin
        if (edge_mode)
            hit = hi_pol ? (line_s & ~prev_q) : (~line_s & prev_q);
        else
            hit = hi_pol ? line_s : ~line_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= IDLE_BIT;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_s;
            pend_q <= hit | force_set | (pend_q & ~ack);
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/irq_gather_outfsm.sv
module irq_gather_outfsm
    import irq_gather_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pulse_mode,
    input  logic hi_pol,
    output logic irq_out
);
    out_state_e state_q;
    out_state_e state_d;
    logic       active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: begin
                if (req) state_d = pulse_mode ? OUT_PULSE : OUT_LEVEL;
            end
            OUT_LEVEL: begin
                if (!req)           state_d = OUT_IDLE;
                else if (pulse_mode) state_d = OUT_HOLD;
            end
            OUT_PULSE: begin
                if (!req)            state_d = OUT_IDLE;
                else if (pulse_mode) state_d = OUT_HOLD;
                else                 state_d = OUT_LEVEL;
            end
            OUT_HOLD: begin
                if (!req)             state_d = OUT_IDLE;
                else if (!pulse_mode) state_d = OUT_LEVEL;
            end
            default: state_d = OUT_IDLE;
        endcase
    end

    always_comb begin
        active  = (state_q == OUT_LEVEL) || (state_q == OUT_PULSE);
        irq_out = active ? hi_pol : ~hi_pol;
    end
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
    import irq_gather_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] smode_q;
    logic [NUM_SRC-1:0] spol_q;
    logic               out_mode_q;
    logic               out_pol_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] line_s;
    logic [NUM_SRC-1:0] ack_vec;
    logic [NUM_SRC-1:0] force_vec;
    logic               req;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q   <= '0;
            smode_q    <= '0;
            spol_q     <= '0;
            out_mode_q <= 1'b0;
            out_pol_q  <= 1'b0;
        end else if (bus_we) begin
            unique case (sel)
                RS_ENABLE: enable_q   <= bus_wdata[NUM_SRC-1:0];
                RS_SMODE:  smode_q    <= bus_wdata[NUM_SRC-1:0];
                RS_SPOL:   spol_q     <= bus_wdata[NUM_SRC-1:0];
                RS_OMODE:  out_mode_q <= bus_wdata[0];
                RS_OPOL:   out_pol_q  <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    assign ack_vec   = (bus_we && sel == RS_STATUS) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign force_vec = (bus_we && sel == RS_FORCE)  ? bus_wdata[NUM_SRC-1:0] : '0;

    irq_gather_sync #(.WIDTH(NUM_SRC), .RESET_BIT(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_src),
        .sync_out (line_s)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        irq_gather_cell #(.IDLE_BIT(1'b1)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_s    (line_s[g]),
            .edge_mode (smode_q[g]),
            .hi_pol    (spol_q[g]),
            .ack       (ack_vec[g]),
            .force_set (force_vec[g]),
            .pending   (status_q[g])
        );
    end

    assign req = |(status_q & enable_q);

    irq_gather_outfsm u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .pulse_mode (out_mode_q),
        .hi_pol     (out_pol_q),
        .irq_out    (irq_out)
    );

    logic [NUM_SRC-1:0] rd_vec;
    always_comb begin
        rd_vec = '0;
        unique case (sel)
            RS_ENABLE: rd_vec = enable_q;
            RS_STATUS: rd_vec = status_q;
            RS_SMODE:  rd_vec = smode_q;
            RS_SPOL:   rd_vec = spol_q;
            RS_OMODE:  rd_vec[0] = out_mode_q;
            RS_OPOL:   rd_vec[0] = out_pol_q;
            default:   rd_vec = '0;
        endcase
    end

    if (PAD_W > 0) begin : g_pad
        assign bus_rdata = {{PAD_W{1'b0}}, rd_vec};
    end else begin : g_nopad
        assign bus_rdata = rd_vec;
    end
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irq_gather_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic               out_mode_q,
    input logic               out_pol_q,
    input logic               bus_we,
    input logic [REG_AW-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_out
);
    logic merged;
    logic out_act;
    assign merged  = |(status_q & enable_q);
    assign out_act = (irq_out == out_pol_q);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_q == '0 && enable_q == '0 && irq_out));

    // R6
    force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RS_FORCE) |=>
        ((status_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    // R7
    idle_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !merged |=> !out_act);

    // R8
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_mode_q && merged) |=> out_act);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_q && out_act) |=> !out_act);
endmodule

bind irq_gather_ctrl irq_gather_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .out_mode_q (out_mode_q),
    .out_pol_q  (out_pol_q),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_out    (irq_out)
);

// File: tb/irq_gather_ctrl_bench.sv
`timescale 1ns/1ps
module irq_gather_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_gather_ctrl u_irq_gather_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #0.5;
        d = bus_rdata;
    endtask

    task automatic apply_reset();
        irq_src = '1; bus_we = 1'b0;
        @(posedge clk); #1; rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        apply_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 register reset", v, 32'h0);
        end
        check("R1 output idle", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        apply_reset();
        wr(3'd0, 32'hA5A5_0001); rd(3'd0, v); check("R2 enable", v, 32'hA5A5_0001);
        wr(3'd2, 32'h1234_5678); rd(3'd2, v); check("R2 mode", v, 32'h1234_5678);
        wr(3'd3, 32'h0F0F_F0F0); rd(3'd3, v); check("R2 polarity", v, 32'h0F0F_F0F0);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R2 out mode", v, 32'h1);
        wr(3'd5, 32'hFFFF_FFFE); rd(3'd5, v); check("R2 out pol", v, 32'h0);
        wr(3'd6, 32'h0000_0000); rd(3'd6, v); check("R2 force reads 0", v, 32'h0);
        rd(3'd7, v); check("R2 spare", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        apply_reset();
        irq_src[0] = 1'b0; tick(4);
        wr(3'd2, 32'h3); wr(3'd3, 32'h1); wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R3 clean start", v, 32'h0);
        irq_src[0] = 1'b1; tick(2);
        rd(3'd1, v); check("R3 not yet", v, 32'h0);
        tick(1);
        rd(3'd1, v); check("R3 rising latched", v, 32'h1);
        irq_src[1] = 1'b0; tick(3);
        rd(3'd1, v); check("R3 falling latched", v, 32'h3);
        irq_src[0] = 1'b0; irq_src[1] = 1'b1; tick(4);
        rd(3'd1, v); check("R3 sticky", v, 32'h3);
    endtask

    task automatic t_level();
        logic [31:0] v;
        apply_reset();
        irq_src[3] = 1'b0; tick(4);
        wr(3'd3, 32'h8); wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R4 start", v, 32'h0);
        irq_src[3] = 1'b1; tick(3);
        rd(3'd1, v); check("R4 high active", v, 32'h8);
        wr(3'd1, 32'h8);
        rd(3'd1, v); check("R4 no clear while active", v, 32'h8);
        irq_src[3] = 1'b0; tick(3);
        rd(3'd1, v); check("R4 held after release", v, 32'h8);
        wr(3'd1, 32'h8);
        rd(3'd1, v); check("R4 cleared", v, 32'h0);
        irq_src[4] = 1'b0; tick(3);
        rd(3'd1, v); check("R4 low active", v, 32'h10);
    endtask

    task automatic t_w1c_force();
        logic [31:0] v;
        apply_reset();
        wr(3'd6, 32'h0000_01F0);
        rd(3'd1, v); check("R6 force sets", v, 32'h0000_01F0);
        rd(3'd6, v); check("R6 force reads 0", v, 32'h0);
        wr(3'd1, 32'h0000_0030);
        rd(3'd1, v); check("R5 ones clear", v, 32'h0000_01C0);
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R5 zeros ignored", v, 32'h0000_01C0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        apply_reset();
        wr(3'd6, 32'h20); tick(2);
        check("R7 masked output idle", {31'b0, irq_out}, 32'h1);
        rd(3'd1, v); check("R7 status kept", v, 32'h20);
        wr(3'd0, 32'h20); tick(1);
        check("R7 unmask raises", {31'b0, irq_out}, 32'h0);
        wr(3'd0, 32'h0); tick(1);
        check("R7 remask idles", {31'b0, irq_out}, 32'h1);
        rd(3'd1, v); check("R7 status after remask", v, 32'h20);
    endtask

    task automatic t_out_level();
        apply_reset();
        wr(3'd5, 32'h1); wr(3'd0, 32'h5);
        check("R8 idle high pol", {31'b0, irq_out}, 32'h0);
        wr(3'd6, 32'h4); tick(1);
        check("R8 active", {31'b0, irq_out}, 32'h1);
        tick(3);
        check("R8 held", {31'b0, irq_out}, 32'h1);
        wr(3'd1, 32'h4); tick(1);
        check("R8 drops", {31'b0, irq_out}, 32'h0);
        irq_src[0] = 1'b0; tick(3);
        check("R8 source latency", {31'b0, irq_out}, 32'h0);
        tick(1);
        check("R8 source raises", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_out_edge();
        apply_reset();
        wr(3'd4, 32'h1); wr(3'd0, 32'h3);
        wr(3'd6, 32'h1); tick(1);
        check("R9 pulse", {31'b0, irq_out}, 32'h0);
        tick(1);
        check("R9 pulse ends", {31'b0, irq_out}, 32'h1);
        tick(3);
        check("R9 no repeat", {31'b0, irq_out}, 32'h1);
        wr(3'd6, 32'h2); tick(1);
        check("R9 no pulse while high", {31'b0, irq_out}, 32'h1);
        wr(3'd1, 32'h3); tick(2);
        wr(3'd6, 32'h1); tick(1);
        check("R9 new pulse", {31'b0, irq_out}, 32'h0);
        tick(1);
        check("R9 second pulse ends", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_spurious();
        logic [31:0] v;
        apply_reset();
        irq_src[6] = 1'b0; tick(3);
        irq_src[6] = 1'b1; tick(3);
        wr(3'd2, 32'h40); wr(3'd3, 32'h40); tick(2);
        rd(3'd1, v); check("R10 stale bit", v, 32'h40);
        wr(3'd1, 32'h40); tick(3);
        rd(3'd1, v); check("R10 cleared for good", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_edge();
        t_level();
        t_w1c_force();
        t_mask();
        t_out_level();
        t_out_edge();
        t_spurious();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule